// File: doc/BRIEF.md
# ROM Overlay RAM Bank Controller

This controller manages a 16 KB block of RAM that can stand in for the 12 KB of ROM at the top of an 8-bit machine's 64 KB address map, $D000-$FFFF. A row of sixteen switch addresses, $C080-$C08F, changes the controller's mode. Any access to one of them counts, whether it is a read or a write. The mode has three parts. The first is whether reads in the overlay area come from RAM or from ROM. The second is whether writes there reach RAM. The third is which of two 4 KB RAM banks backs $D000-$DFFF. The upper 8 KB, $E000-$FFFF, has a single RAM region and no bank choice.

For every valid CPU cycle in the overlay area the controller drives one of three strobes: a ROM select, a RAM read enable or a RAM write enable. It also drives a 14-bit RAM address. Writes to RAM are protected by an arming step. Two back-to-back reads of an odd switch address are needed to open RAM for writing. Read source and write enable are independent, so one read-modify-write can fetch from ROM and store into RAM. The mode registers change on the clock edge that ends a switch access. The strobes are combinational from the current address and the current mode.

Top module: `rom_overlay_ctrl`

## Requirements
- R1: Reset (rst_n low) puts the controller in this mode: reads from RAM, bank 2 selected, writes blocked, arm flag cleared. This is the same mode that a read of $C080 gives.
- R2: Any valid access, read or write, to $C080-$C08F copies address bit 3 into the bank choice for the next cycles. Bit 3 = 1 selects bank 1 and bit 3 = 0 selects bank 2.
- R3: Any valid switch access also sets the read source from address bits 1:0. The values 00 and 11 select RAM reads. The values 01 and 10 select ROM reads.
- R4: A valid read of a switch address with bit 0 = 1 sets the arm flag. If the arm flag was already set by the previous switch access, that read also sets write enable. A single odd read never sets write enable.
- R5: A valid write access to a switch address with bit 0 = 1 clears the arm flag and leaves write enable unchanged. So the sequence read $C08B, write $C08B, read $C08B leaves RAM bank 1 readable but not writable.
- R6: Any valid switch access with bit 0 = 0 clears both the arm flag and write enable.
- R7: A valid read in $D000-$FFFF asserts ram_rd_en when RAM is the read source, and rom_cs otherwise. A valid write there asserts ram_wr_en only when write enable is set. ROM is never selected on a write.
- R8: In $D000-$DFFF, ram_addr is the low 12 address bits plus 0x0000 for bank 1 or plus 0x1000 for bank 2. In $E000-$FFFF, ram_addr is (address - $E000) + 0x2000, whatever the bank choice.
- R9: After two reads of $C081, a read-modify-write in the overlay area reads the byte from ROM and stores the result into bank 2 RAM.
- R10: Accesses outside $C080-$C08F and $D000-$FFFF assert no strobe and change no mode bit, including the arm flag. Cycles with cpu_vld low do the same.
- R11: At most one of rom_cs, ram_rd_en and ram_wr_en is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one CPU cycle per edge when cpu_vld is high |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | 1 = read access, 0 = write access |
| cpu_vld | input | 1 | Current cycle carries a real CPU access |
| rom_cs | output | 1 | ROM select for an overlay read |
| ram_rd_en | output | 1 | RAM read enable |
| ram_wr_en | output | 1 | RAM write enable |
| ram_addr | output | 14 | Address into the 16 KB RAM |

## Verification
Most mode faults stay hidden until the next access to the overlay area. A wrong bank bit shows up as a ram_addr off by 0x1000 on the next $D000-page access. A wrong read-source bit swaps rom_cs and ram_rd_en on the next overlay read. An arm flag that is wrongly set or wrongly cleared shows up only on a later overlay write, as a missing or extra ram_wr_en. That fault can lie hidden across any number of unrelated cycles. The bench therefore compares every cycle against a behavioural model. It also replays whole read-modify-write sequences against modelled ROM and RAM contents, so a corrupted bank shows up as a wrong stored byte.

// File: rtl/rovl_pkg.sv
// Shared types for the ROM overlay controller.
// Assumes: one access per clock when valid; the package has no logic of its own.
package rovl_pkg;
    // Region an access falls into.
    typedef enum logic [1:0] {
        REG_NONE   = 2'd0,
        REG_SWITCH = 2'd1,
        REG_BANKED = 2'd2,
        REG_COMMON = 2'd3
    } region_e;

    // Mode kept between accesses.
    typedef struct packed {
        logic bank1;   // 1 = bank 1 backs the banked page, 0 = bank 2
        logic rd_ram;  // 1 = overlay reads come from RAM
        logic wr_en;   // 1 = overlay writes reach RAM
        logic arm;     // first odd read seen, waiting for the second
    } mode_t;
endpackage

// File: rtl/rovl_decode.sv
// Address classifier: sorts each valid access into the switch row, the banked
// page, the common overlay area or nothing.
// Assumes: the switch row is 16 addresses that share the upper ADDR_W-4 bits.
module rovl_decode
    import rovl_pkg::*;
#(
    parameter int              ADDR_W     = 16,
    parameter logic [ADDR_W-5:0] SW_TAG   = 12'hC08,
    parameter logic [3:0]      BANKED_NIB = 4'hD
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              vld,
    output region_e           region
);
    logic [3:0] top_nib;
    assign top_nib = addr[ADDR_W-1 -: 4];

    // Classify the current address.
    always_comb begin
        region = REG_NONE;
        if (vld) begin
            if (addr[ADDR_W-1:4] == SW_TAG)   region = REG_SWITCH;
            else if (top_nib == BANKED_NIB)   region = REG_BANKED;
            else if (top_nib > BANKED_NIB)    region = REG_COMMON;
        end
    end
endmodule

// File: rtl/rovl_mode.sv
// Mode register: updates bank, read source, write enable and the arm flag on
// each valid switch access. Holds otherwise.
// Assumes: synchronous active-low reset; region already gated by cpu_vld.
module rovl_mode
    import rovl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  region_e    region,
    input  logic [3:0] sw_sel,
    input  logic       rd,
    output mode_t      mode
);
    mode_t nxt;

    // Next mode from the switch address and the access direction.
    always_comb begin
        nxt = mode;
        if (region == REG_SWITCH) begin
            nxt.bank1  = sw_sel[3];
            nxt.rd_ram = (sw_sel[1] == sw_sel[0]);
            if (!sw_sel[0]) begin
                nxt.arm   = 1'b0;
                nxt.wr_en = 1'b0;
            end else if (rd) begin
                nxt.wr_en = mode.wr_en | mode.arm;
                nxt.arm   = 1'b1;
            end else begin
                nxt.arm   = 1'b0;
            end
        end
    end

    // Register the mode; reset equals the even read-RAM bank-2 mode.
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= '{bank1: 1'b0, rd_ram: 1'b1, wr_en: 1'b0, arm: 1'b0};
        else        mode <= nxt;
    end
endmodule

// File: rtl/rovl_route.sv
// Memory router: turns the region, direction and mode into strobes and a RAM address.
// Assumes: the banked page is one page of 2**PAGE_W bytes; the common area is
// the two pages above it.
module rovl_route
    import rovl_pkg::*;
#(
    parameter  int PAGE_W = 12,
    localparam int RAM_AW = PAGE_W + 2
) (
    input  region_e           region,
    input  logic [PAGE_W:0]   addr_lo,
    input  logic              rd,
    input  mode_t             mode,
    output logic              rom_cs,
    output logic              ram_rd_en,
    output logic              ram_wr_en,
    output logic [RAM_AW-1:0] ram_addr
);
    logic in_ovl;
    assign in_ovl = (region == REG_BANKED) || (region == REG_COMMON);

    // Pick the one strobe this access needs.
    always_comb begin
        rom_cs    = in_ovl &&  rd && !mode.rd_ram;
        ram_rd_en = in_ovl &&  rd &&  mode.rd_ram;
        ram_wr_en = in_ovl && !rd &&  mode.wr_en;
    end

    // Map the CPU address onto the RAM: bank 1, bank 2, then the common area.
    always_comb begin
        if (region == REG_COMMON) ram_addr = {1'b1, addr_lo[PAGE_W:0]};
        else                      ram_addr = {1'b0, !mode.bank1, addr_lo[PAGE_W-1:0]};
    end
endmodule

// File: rtl/rom_overlay_ctrl.sv
// Top of the ROM overlay controller: decodes the switch row, keeps the mode and
// routes overlay accesses to ROM or RAM.
// Assumes: a 16-bit address map with the overlay at the top 12 KB, one access per clock.
module rom_overlay_ctrl
    import rovl_pkg::*;
#(
    parameter  int ADDR_W = 16,
    parameter  int PAGE_W = 12,
    localparam int RAM_AW = PAGE_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_vld,
    output logic              rom_cs,
    output logic              ram_rd_en,
    output logic              ram_wr_en,
    output logic [RAM_AW-1:0] ram_addr
);
    region_e region;
    mode_t   mode_q;

    rovl_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (cpu_addr),
        .vld    (cpu_vld),
        .region (region)
    );

    rovl_mode u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .region (region),
        .sw_sel (cpu_addr[3:0]),
        .rd     (cpu_rd),
        .mode   (mode_q)
    );

    rovl_route #(.PAGE_W(PAGE_W)) u_route (
        .region    (region),
        .addr_lo   (cpu_addr[PAGE_W:0]),
        .rd        (cpu_rd),
        .mode      (mode_q),
        .rom_cs    (rom_cs),
        .ram_rd_en (ram_rd_en),
        .ram_wr_en (ram_wr_en),
        .ram_addr  (ram_addr)
    );
endmodule

// File: rtl/rovl_chk.sv
// Checker for the ROM overlay controller; attached to the top with bind.
// Assumes: the mode register is visible as mode_q inside the top.
module rovl_chk
    import rovl_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_rd,
    input logic              cpu_vld,
    input logic              rom_cs,
    input logic              ram_rd_en,
    input logic              ram_wr_en,
    input mode_t             mode
);
    logic sw_hit;
    assign sw_hit = cpu_vld && (cpu_addr[ADDR_W-1:4] == 12'hC08);

    p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_cs, ram_rd_en, ram_wr_en}));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_vld |-> !(rom_cs || ram_rd_en || ram_wr_en));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_hit |=> $stable(mode));

    p_bank_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_hit |=> (mode.bank1 == $past(cpu_addr[3])));

    p_two_reads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode.wr_en) |-> $past(sw_hit && cpu_rd && cpu_addr[0] && mode.arm));

    p_write_disarms_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_hit && !cpu_rd) |=> !mode.arm);

    p_even_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_hit && !cpu_addr[0]) |=> (!mode.arm && !mode.wr_en));

    p_no_rom_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |-> !rom_cs);
endmodule

bind rom_overlay_ctrl rovl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_rd    (cpu_rd),
    .cpu_vld   (cpu_vld),
    .rom_cs    (rom_cs),
    .ram_rd_en (ram_rd_en),
    .ram_wr_en (ram_wr_en),
    .mode      (mode_q)
);

// File: tb/sim_rom_overlay_ctrl.sv
module sim_rom_overlay_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_rd = 1'b1;
    logic        cpu_vld = 1'b0;
    logic        rom_cs, ram_rd_en, ram_wr_en;
    logic [13:0] ram_addr;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Reference mode, kept behaviourally.
    bit m_bank1, m_rdram, m_wen, m_arm;
    // Sparse RAM contents and data bus.
    byte unsigned ram [int];
    byte unsigned bus;

    always #5 clk = ~clk;

    rom_overlay_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_vld(cpu_vld), .rom_cs(rom_cs), .ram_rd_en(ram_rd_en),
        .ram_wr_en(ram_wr_en), .ram_addr(ram_addr)
    );

    function automatic byte unsigned rom_byte(input logic [15:0] a);
        if (a == 16'hD17B) return 8'h53;
        if (a == 16'hFE1F) return 8'h60;
        return a[7:0];
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_bank1 = 0; m_rdram = 1; m_wen = 0; m_arm = 0;
    endtask

    // One CPU cycle: drive, compare with the model, move the RAM data, clock.
    task automatic cyc(input logic [15:0] a, input bit rd, input bit vld, input string tag);
        bit sw, ovl, common;
        int exp_addr;
        @(negedge clk);
        cpu_addr = a; cpu_rd = rd; cpu_vld = vld;
        #1;
        sw     = vld && (a[15:4] == 12'hC08);
        ovl    = vld && (a >= 16'hD000);
        common = a >= 16'hE000;
        check(tag, {rom_cs, ram_rd_en, ram_wr_en},
              {ovl && rd && !m_rdram, ovl && rd && m_rdram, ovl && !rd && m_wen});
        if (ovl && (ram_rd_en || ram_wr_en)) begin
            exp_addr = common ? (int'(a) - 'hE000 + 'h2000)
                              : ((int'(a) & 'hFFF) + (m_bank1 ? 0 : 'h1000));
            check(tag, int'(ram_addr), exp_addr);
        end
        if (ovl && rd) bus = rom_cs ? rom_byte(a)
                          : (ram.exists(int'(ram_addr)) ? ram[int'(ram_addr)] : 8'h00);
        if (ram_wr_en) ram[int'(ram_addr)] = bus;
        @(posedge clk);
        if (sw) begin
            m_bank1 = a[3];
            m_rdram = (a[1] == a[0]);
            if (!a[0]) begin m_arm = 0; m_wen = 0; end
            else if (rd) begin if (m_arm) m_wen = 1; m_arm = 1; end
            else m_arm = 0;
        end
    endtask

    // Read-modify-write through the controller, as a CPU increment would.
    task automatic incr(input logic [15:0] a, input string tag);
        cyc(a, 1, 1, tag);
        bus = bus + 8'd1;
        cyc(a, 0, 1, tag);
    endtask

    task automatic live_read(input logic [15:0] a, input int exp, input string tag);
        cyc(a, 1, 1, tag);
        check(tag, int'(bus), exp);
    endtask

    // Full scenario: preset RAM, run switch accesses, increment two bytes, check five values.
    task automatic scenario(input logic [15:0] sw[$], input bit wr[$], input int q[5], input string tag);
        ram.delete();
        ram['h017B] = 8'h55; ram['h117B] = 8'hAA; ram['h3E1F] = 8'h55;
        cyc(16'hC080, 1, 1, tag);
        foreach (sw[i]) cyc(sw[i], !wr[i], 1, tag);
        incr(16'hD17B, tag);
        incr(16'hFE1F, tag);
        live_read(16'hD17B, q[0], tag);
        live_read(16'hFE1F, q[1], tag);
        check(tag, int'(ram['h017B]), q[2]);
        check(tag, int'(ram['h117B]), q[3]);
        check(tag, int'(ram['h3E1F]), q[4]);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset mode reads bank 2 RAM, blocks writes
        cyc(16'hD123, 1, 1, "R1");
        check("R1", int'(ram_addr), 'h1123);
        cyc(16'hD123, 0, 1, "R1");
        // R2 R3: walk every switch address, probe reads in both areas
        for (int s = 0; s < 16; s++) begin
            cyc(16'hC080 | 16'(s), 1, 1, "R3");
            cyc(16'hD456, 1, 1, "R2");
            cyc(16'hF001, 1, 1, "R8");
            cyc(16'hD456, 0, 1, "R7");
        end
        // R2 R3 via write accesses to the switches
        cyc(16'hC08A, 0, 1, "R3");
        cyc(16'hDFFF, 1, 1, "R2");
        cyc(16'hC083, 0, 1, "R3");
        cyc(16'hD000, 1, 1, "R2");
        // R4: single odd read does not open writes; second one does
        cyc(16'hC08B, 1, 1, "R4");
        cyc(16'hD010, 0, 1, "R4");
        cyc(16'hC08B, 1, 1, "R4");
        cyc(16'hD010, 0, 1, "R4");
        cyc(16'hE000, 0, 1, "R8");
        // R6: even access clears write enable
        cyc(16'hC088, 0, 1, "R6");
        cyc(16'hD010, 0, 1, "R6");
        // R5: write to an odd switch disarms but keeps write enable
        cyc(16'hC081, 1, 1, "R5");
        cyc(16'hC081, 1, 1, "R5");
        cyc(16'hC089, 0, 1, "R5");
        cyc(16'hD020, 0, 1, "R5");
        cyc(16'hC080, 1, 1, "R6");
        cyc(16'hC083, 1, 1, "R5");
        cyc(16'hC083, 0, 1, "R5");
        cyc(16'hC083, 1, 1, "R5");
        cyc(16'hD020, 0, 1, "R5");
        // R10: other addresses and idle cycles keep the arm flag
        cyc(16'hC080, 1, 1, "R10");
        cyc(16'hC089, 1, 1, "R10");
        cyc(16'hC090, 0, 1, "R10");
        cyc(16'hC07F, 1, 1, "R10");
        cyc(16'h1234, 0, 1, "R10");
        cyc(16'hC080, 1, 0, "R10");
        cyc(16'hD333, 0, 0, "R10");
        cyc(16'hC089, 1, 1, "R10");
        cyc(16'hD333, 0, 1, "R10");
        // R9 and companions: whole read-modify-write scenarios
        scenario('{16'hC088}, '{0}, '{'h55, 'h55, 'h55, 'hAA, 'h55}, "R3");
        scenario('{16'hC081, 16'hC081}, '{0, 0}, '{'h53, 'h60, 'h55, 'h54, 'h61}, "R9");
        scenario('{16'hC08B, 16'hC08B}, '{0, 0}, '{'h56, 'h56, 'h56, 'hAA, 'h56}, "R4");
        scenario('{16'hC08B, 16'hC08B, 16'hC08B}, '{0, 1, 0}, '{'h55, 'h55, 'h55, 'hAA, 'h55}, "R5");
        // R1: reset mid-run returns to the reset mode
        cyc(16'hC08B, 1, 1, "R1");
        cyc(16'hC08B, 1, 1, "R1");
        @(negedge clk); rst_n = 1'b0; cpu_vld = 1'b0;
        @(posedge clk); model_reset();
        #1 rst_n = 1'b1;
        cyc(16'hD555, 1, 1, "R1");
        cyc(16'hD555, 0, 1, "R1");
        cyc(16'hC08B, 1, 1, "R1");
        cyc(16'hD555, 0, 1, "R1");
        finish_run();
    end
endmodule